// File: doc/BRIEF.md
# Fixed-Direction GPIO Port with Edge Interrupts

This block is a byte-wide GPIO peripheral on a small 8-bit register bus. Its eight pin positions are split permanently: the low four are driven outputs held in a latch, the high four are sampled inputs. Each input is synchronised to the block clock and watched for edges. A per-input 2-bit selector chooses which edges count: none, falling, rising or both. A qualifying edge sets a sticky pending bit. Software clears pending bits by writing ones to them. One interrupt line to the host is high while any pending bit is set.

Software reads the direction register to learn which pins are inputs. It writes the output latch through the data register and reads input levels from the same register. It programs the edge selectors, and in its interrupt handler it reads the pending register and writes the same value back. The bus is a single-cycle write strobe with an address and write data, plus a combinational read-data path.

Top module: `gpio_edge_irq`

## Requirements
- R1: Address 0 (direction) always reads 0x0F. Writes to it have no effect.
- R2: A write to address 1 (data) loads bus_wdata[3:0] into the output latch, which drives pin_out and reads back on bits 3:0 of address 1.
- R3: Bits 7:4 of address 1 return pin_in[3:0] after a two-flop synchroniser, so a pin change reaches the read path on the second rising clock edge. Writes to bits 7:4 have no effect.
- R4: Address 3 (edge select) is readable and writable. Input k uses bits [2k+1:2k], where bit 2k enables falling edges and bit 2k+1 enables rising edges.
- R5: With selector 2'b10, a rising edge on input k sets pending bit k and a falling edge does not.
- R6: With selector 2'b01, a falling edge on input k sets pending bit k and a rising edge does not.
- R7: With selector 2'b11, both rising and falling edges on input k set pending bit k.
- R8: With selector 2'b00, input k never sets pending bit k.
- R9: Address 4 (pending) shows bit k for input k on bits 3:0, and bits 7:4 read zero. Writing a 1 to bit k clears it. Writing a 0 leaves it unchanged.
- R10: If a qualifying edge and a clearing write reach the same pending bit in the same cycle, the bit stays set.
- R11: irq is high exactly when at least one pending bit is set.
- R12: After reset, pin_out, the edge-select register and all pending bits are zero, and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 4 | Asynchronous input pins (GPIO 4 to 7) |
| pin_out | output | 4 | Output pins (GPIO 0 to 3) |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong edge-select decode or a swapped field shows up as a pending bit and an irq level that disagree with the programmed selector. This is visible on the third rising edge after the pin change, when the pending register is read. A synchroniser with the wrong depth shifts both the data-register read and the pending set by one cycle, and checks taken at the exact cycle catch this. A lost-edge race with a clearing write leaves a pending bit at zero that should be one. This shows on the very next read of the pending register and on irq dropping when it should not.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned REG_AW = 3;

  // register byte offsets (software decodes these)
  localparam logic [REG_AW-1:0] OFS_DIR  = 3'd0;
  localparam logic [REG_AW-1:0] OFS_DATA = 3'd1;
  localparam logic [REG_AW-1:0] OFS_SEL  = 3'd3;
  localparam logic [REG_AW-1:0] OFS_PEND = 3'd4;

  // per-input edge selector: bit 0 falling, bit 1 rising
  typedef enum logic [1:0] {
    SEL_OFF  = 2'b00,
    SEL_FALL = 2'b01,
    SEL_RISE = 2'b10,
    SEL_ANY  = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/gpio_edge_rst_sync.sv
module gpio_edge_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_in_sync.sv
module gpio_edge_in_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_raw,
  output logic [W-1:0] lvl_now,
  output logic [W-1:0] lvl_prev
);
  // STAGES synchroniser flops plus one history flop
  localparam int unsigned DEPTH = STAGES + 1;

  logic [W-1:0] stage_q [DEPTH];
  logic [W-1:0] stage_d [DEPTH];

  always_comb begin
    stage_d[0] = pin_raw;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_chain
    always_comb begin
      stage_d[s] = stage_q[s-1];
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign lvl_now  = stage_q[STAGES-1];
  assign lvl_prev = stage_q[STAGES];
endmodule

// File: rtl/gpio_edge_pend.sv
module gpio_edge_pend #(
  parameter int unsigned N_IN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   lvl_now,
  input  logic [N_IN-1:0]   lvl_prev,
  input  logic [2*N_IN-1:0] sel,
  input  logic [N_IN-1:0]   clr,
  output logic [N_IN-1:0]   evt,
  output logic [N_IN-1:0]   pend
);
  import gpio_edge_pkg::*;

  logic [N_IN-1:0] pend_d;

  for (genvar k = 0; k < N_IN; k++) begin : g_pin
    edge_sel_e mode;
    logic      rise;
    logic      fall;

    always_comb begin
      mode     = edge_sel_e'(sel[2*k +: 2]);
      rise     = lvl_now[k] & ~lvl_prev[k];
      fall     = ~lvl_now[k] & lvl_prev[k];
      evt[k]   = (rise & mode[1]) | (fall & mode[0]);
      // a new event outranks a clear in the same cycle
      pend_d[k] = evt[k] | (pend[k] & ~clr[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_d;
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int unsigned N_OUT       = 4,
  parameter int unsigned N_IN        = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              bus_addr,
  input  logic                    bus_wr,
  input  logic [N_OUT+N_IN-1:0]   bus_wdata,
  output logic [N_OUT+N_IN-1:0]   bus_rdata,
  input  logic [N_IN-1:0]         pin_in,
  output logic [N_OUT-1:0]        pin_out,
  output logic                    irq
);
  import gpio_edge_pkg::*;

  localparam int unsigned DW   = N_OUT + N_IN;
  localparam int unsigned SELW = 2 * N_IN;
  localparam logic [DW-1:0] DIR_WORD = {{N_IN{1'b0}}, {N_OUT{1'b1}}};

  logic            rst_n_int;
  logic [N_IN-1:0] lvl_now;
  logic [N_IN-1:0] lvl_prev;
  logic [N_IN-1:0] evt;
  logic [N_IN-1:0] pend;
  logic [N_IN-1:0] clr;

  logic [N_OUT-1:0] out_q, out_d;
  logic [SELW-1:0]  sel_q, sel_d;
  logic             we_data, we_sel, we_pend;

  gpio_edge_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  gpio_edge_in_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .pin_raw  (pin_in),
    .lvl_now  (lvl_now),
    .lvl_prev (lvl_prev)
  );

  gpio_edge_pend #(.N_IN(N_IN)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .lvl_now  (lvl_now),
    .lvl_prev (lvl_prev),
    .sel      (sel_q),
    .clr      (clr),
    .evt      (evt),
    .pend     (pend)
  );

  // write decode
  always_comb begin
    we_data = bus_wr && (bus_addr == OFS_DATA);
    we_sel  = bus_wr && (bus_addr == OFS_SEL);
    we_pend = bus_wr && (bus_addr == OFS_PEND);
    clr     = we_pend ? bus_wdata[N_IN-1:0] : '0;
  end

  // next state with explicit enables
  always_comb begin
    out_d = out_q;
    sel_d = sel_q;
    if (we_data) out_d = bus_wdata[N_OUT-1:0];
    if (we_sel)  sel_d = bus_wdata[SELW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      out_q <= '0;
      sel_q <= '0;
    end else begin
      out_q <= out_d;
      sel_q <= sel_d;
    end
  end

  // read path
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_DIR:  bus_rdata = DIR_WORD;
      OFS_DATA: bus_rdata = {lvl_now, out_q};
      OFS_SEL:  bus_rdata[SELW-1:0] = sel_q;
      OFS_PEND: bus_rdata[N_IN-1:0] = pend;
      default:  bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign irq     = |pend;
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int unsigned N_OUT = 4,
  parameter int unsigned N_IN  = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2:0]            bus_addr,
  input logic                  bus_wr,
  input logic [N_OUT+N_IN-1:0] bus_wdata,
  input logic [N_OUT+N_IN-1:0] bus_rdata,
  input logic [N_OUT-1:0]      pin_out,
  input logic                  irq,
  input logic [N_IN-1:0]       evt,
  input logic [N_IN-1:0]       pend
);
  logic [N_IN-1:0] clr_only;
  assign clr_only = (bus_wr && bus_addr == 3'd4) ? (bus_wdata[N_IN-1:0] & ~evt) : '0;

  a_r1_dir_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd0) |-> (bus_rdata == {{N_IN{1'b0}}, {N_OUT{1'b1}}}));

  a_r2_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd1) |=> (pin_out == $past(bus_wdata[N_OUT-1:0])));

  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_only != '0) |=> ((pend & $past(clr_only)) == '0));

  a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));

  a_r8_set_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pend & ~evt) != '0) |=> ((pend & $past(~pend & ~evt)) == '0));

  a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(evt) != '0));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.N_OUT(N_OUT), .N_IN(N_IN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .irq       (irq),
  .evt       (evt),
  .pend      (pend)
);

// File: tb/sim_gpio_edge_irq.sv
`timescale 1ns/1ps
module sim_gpio_edge_irq;
  logic       clk;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [3:0] pin_in;
  logic [3:0] pin_out;
  logic       irq;

  int n_chk;
  int n_err;
  bit done;

  gpio_edge_irq u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #800000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=running expected=finished");
    if (!done) $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    n_chk = 0; n_err = 0; done = 0;
    rst_n = 1'b0; bus_addr = 3'd0; bus_wr = 1'b0; bus_wdata = 8'h00; pin_in = 4'h0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R12 reset state
    check("R12 pin_out", {4'h0, pin_out}, 8'h00);
    check("R12 irq", {7'h0, irq}, 8'h00);
    rd(3'd3, v); check("R12 select", v, 8'h00);
    rd(3'd4, v); check("R12 pending", v, 8'h00);

    // R1 direction constant, write ignored
    rd(3'd0, v); check("R1 dir", v, 8'h0F);
    wr(3'd0, 8'hA5);
    rd(3'd0, v); check("R1 dir after write", v, 8'h0F);

    // R2/R3 sweep: outputs and synchronised inputs, upper write bits ignored
    for (int o = 0; o < 16; o++) begin
      pin_in = 4'(o ^ 4'h9);
      wr(3'd1, {~4'(o), 4'(o)});
      check("R2 pin_out", {4'h0, pin_out}, {4'h0, 4'(o)});
      idle(2);
      rd(3'd1, v); check("R3 data read", v, {4'(o ^ 4'h9), 4'(o)});
    end
    // R3 sync latency: visible after the second edge, not the first
    wr(3'd1, 8'h00);
    pin_in = 4'h0; idle(4);
    pin_in = 4'hF; @(negedge clk);
    rd(3'd1, v); check("R3 one edge", v, 8'h00);
    @(negedge clk);
    rd(3'd1, v); check("R3 two edges", v, 8'hF0);
    pin_in = 4'h0; idle(4);

    // R4 select register readback
    wr(3'd3, 8'hE4);
    rd(3'd3, v); check("R4 select rw", v, 8'hE4);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'hFF);

    // R5..R8 sweep: each pin, each selector, each edge direction
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int dirn = 0; dirn < 2; dirn++) begin
          logic en;
          logic [7:0] expv;
          // set level opposite to edge end point without a pending event
          wr(3'd3, 8'h00);
          pin_in[p] = (dirn == 0) ? 1'b0 : 1'b1;
          idle(4);
          wr(3'd4, 8'hFF);
          wr(3'd3, 8'(m << (2*p)));
          pin_in[p] = ~pin_in[p];
          idle(4);
          en = (dirn == 0) ? m[1] : m[0];
          expv = en ? 8'(1 << p) : 8'h00;
          rd(3'd4, v);
          if (m == 0)      check("R8 masked", v, expv);
          else if (m == 1) check("R6 falling sel", v, expv);
          else if (m == 2) check("R5 rising sel", v, expv);
          else             check("R7 both sel", v, expv);
          check("R11 irq level", {7'h0, irq}, {7'h0, en});
        end
      end
      pin_in[p] = 1'b0;
    end
    wr(3'd3, 8'h00); idle(4); wr(3'd4, 8'hFF);

    // R9 partial write-one-to-clear
    wr(3'd3, 8'hAA);
    pin_in = 4'hF; idle(4);
    rd(3'd4, v); check("R9 all set", v, 8'h0F);
    wr(3'd4, 8'hF5);
    rd(3'd4, v); check("R9 partial clear", v, 8'h0A);
    check("R11 irq held", {7'h0, irq}, 8'h01);
    wr(3'd4, 8'h0A);
    rd(3'd4, v); check("R9 cleared", v, 8'h00);
    check("R11 irq low", {7'h0, irq}, 8'h00);

    // R10 edge and clear collide on pin 2; pin 0 only clears
    wr(3'd3, 8'h55);
    pin_in = 4'hE; idle(4);
    rd(3'd4, v); check("R10 setup", v, 8'h01);
    pin_in = 4'hA;
    idle(2);
    wr(3'd4, 8'hFF);
    rd(3'd4, v); check("R10 edge wins", v, 8'h04);
    check("R11 irq after race", {7'h0, irq}, 8'h01);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule